// File: doc/BRIEF.md
# DMA Launch Control and Status Registers

This block is a small host-visible register file that sits between a host register port and a streaming DMA engine. The host uses it to set up a transfer (packet length, number of packets, target address), to arm the engine with a soft reset, and to launch the transfer with a single write. The block drives the transfer parameters and one-cycle pulses for launch and soft reset. It reports the engine's busy and completion state back through a status word.

The launch order is enforced in hardware. After a hardware reset, and after every accepted launch, the block is disarmed. Only a soft-reset write arms it again. A launch request is refused if the block is not armed or if the packet length or packet count is zero. A refused request sets an error flag and produces no pulse. While the engine reports busy, the transfer parameters are frozen against host writes. A general-purpose host control word is kept alongside the DMA registers.

Reads are combinational from the current address. Writes take effect at the clock edge on which `csr_wr` is high.

Top module: `dma_csr_top`

## Requirements
- R1: After the synchronous reset `rst`, every output is 0, the block is disarmed, and every register reads as 0.
- R2: A write at offset 0x08 sets the packet length (low 16 bits of write data). A write at 0x0C sets the packet count (low 16 bits). A write at 0x10 sets the destination address (32 bits). A write at 0x14 sets the host control word (32 bits). Each takes effect on the following cycle on its output and reads back at the same offset.
- R3: A write at offset 0x00 with bit 0 = 1 raises `soft_rst` for exactly the next cycle. The same write clears the done and error flags and sets the armed flag. Offset 0x00 always reads 0, and a write there with bit 0 = 0 changes nothing.
- R4: A write at offset 0x04 with bit 0 = 1 is accepted when the block is armed and both packet length and count are nonzero. An accepted write raises `dma_start` for exactly the next cycle and clears the armed, done and error flags.
- R5: A launch request made while packet length or packet count is 0 produces no `dma_start` and sets the error flag.
- R6: A launch request made while the block is not armed produces no `dma_start` and sets the error flag. This covers the state after hardware reset and the state after a previous accepted launch with no soft reset since.
- R7: The status word at offset 0x04 reads {armed in bit 0, `eng_busy` in bit 1, done in bit 2, error in bit 3}, with all other bits 0. Busy follows `eng_busy` in the same cycle. Done is set the cycle after `eng_done` and holds until a soft reset or an accepted launch, which take priority over a simultaneous `eng_done`.
- R8: While `eng_busy` is 1, writes to offsets 0x08, 0x0C and 0x10 are ignored.
- R9: Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 read 0, and writes to them change nothing. A write at 0x04 with bit 0 = 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 8 | Register byte offset |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr` |
| eng_busy | input | 1 | Engine transfer in progress |
| eng_done | input | 1 | Engine completion pulse |
| dma_start | output | 1 | One-cycle launch pulse |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| dma_pkt_size | output | 16 | Packet length |
| dma_pkt_count | output | 16 | Number of packets |
| dma_dest_addr | output | 32 | Destination address |
| host_ctrl | output | 32 | General host control word |

## Verification
The hardest states to reach are the collisions between host writes and engine feedback. Two cases matter most: an `eng_done` pulse arriving on the very edge of a soft-reset or accepted-launch write, where the clear must win, and a parameter write landing while `eng_busy` is high. Directed sequences line these up deliberately. A disarmed launch is provoked both straight after hardware reset and immediately after an accepted launch. A long pseudo-random phase then mixes writes, busy and done against a behavioural model compared every cycle.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

    // Register byte offsets
    localparam int OFS_SRST  = 'h00;
    localparam int OFS_CTL   = 'h04;
    localparam int OFS_SIZE  = 'h08;
    localparam int OFS_CNT   = 'h0C;
    localparam int OFS_DEST  = 'h10;
    localparam int OFS_HOST  = 'h14;

    // Bit positions in the control/status and reset words
    localparam int BIT_GO    = 0;
    localparam int BIT_SRST  = 0;

    // Per-register selects coming out of the decoder
    typedef struct packed {
        logic srst;
        logic ctl;
        logic size;
        logic cnt;
        logic dest;
        logic host;
    } csr_sel_t;

    // Status word, bit 3 down to bit 0
    typedef struct packed {
        logic err;
        logic done;
        logic busy;
        logic ready;
    } dma_stat_t;

    localparam int STAT_W = $bits(dma_stat_t);

    function automatic logic any_sel(csr_sel_t s);
        return s.srst | s.ctl | s.size | s.cnt | s.dest | s.host;
    endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output csr_sel_t          sel
);

    always_comb begin
        sel      = '0;
        sel.srst = (addr == ADDR_W'(OFS_SRST));
        sel.ctl  = (addr == ADDR_W'(OFS_CTL));
        sel.size = (addr == ADDR_W'(OFS_SIZE));
        sel.cnt  = (addr == ADDR_W'(OFS_CNT));
        sel.dest = (addr == ADDR_W'(OFS_DEST));
        sel.host = (addr == ADDR_W'(OFS_HOST));
    end

endmodule

// File: rtl/csr_field.sv
module csr_field #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         lock,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en && !lock)
            q <= d;
    end

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && lock) |=> $stable(q)) else $error("locked field moved"); // R8

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !lock) |=> (q == $past(d))) else $error("write lost"); // R2

endmodule

// File: rtl/dma_launch_ctrl.sv
module dma_launch_ctrl
    import dma_csr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      srst_wr,
    input  logic      start_wr,
    input  logic      cfg_ok,
    input  logic      eng_busy,
    input  logic      eng_done,
    output dma_stat_t stat,
    output logic      dma_start,
    output logic      soft_rst
);

    logic ready_q, done_q, err_q, start_q, srst_q;
    logic accept;

    assign accept = start_wr && ready_q && cfg_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            start_q <= 1'b0;
            srst_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            srst_q  <= srst_wr;
            if (eng_done)
                done_q <= 1'b1;
            if (srst_wr) begin
                ready_q <= 1'b1;
                done_q  <= 1'b0;
                err_q   <= 1'b0;
            end else if (start_wr) begin
                if (accept) begin
                    start_q <= 1'b1;
                    ready_q <= 1'b0;
                    done_q  <= 1'b0;
                    err_q   <= 1'b0;
                end else begin
                    err_q   <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        stat.ready = ready_q;
        stat.busy  = eng_busy;
        stat.done  = done_q;
        stat.err   = err_q;
    end

    assign dma_start = start_q;
    assign soft_rst  = srst_q;

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dma_start |=> !dma_start) else $error("start longer than a cycle"); // R4

    AST_START_DISARMS: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> (!stat.ready && !stat.err && !stat.done)) else $error("launch left flags"); // R4

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (stat.ready && !stat.done && !stat.err)) else $error("soft reset left flags"); // R3

    AST_REFUSED_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (start_wr && !srst_wr && !(stat.ready && cfg_ok)) |=> (!dma_start && stat.err))
        else $error("refused launch misbehaved"); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat.done && !srst_wr && !start_wr) |=> stat.done) else $error("done dropped"); // R7

endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 32,
    parameter int SIZE_W         = 16,
    parameter int CNT_W          = 16,
    parameter int DEST_W         = 32,
    parameter bit LOCK_WHEN_BUSY = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_wr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    output logic              dma_start,
    output logic              soft_rst,
    output logic [SIZE_W-1:0] dma_pkt_size,
    output logic [CNT_W-1:0]  dma_pkt_count,
    output logic [DEST_W-1:0] dma_dest_addr,
    output logic [DATA_W-1:0] host_ctrl
);

    localparam int PAD_STAT = DATA_W - STAT_W;
    localparam int PAD_SIZE = DATA_W - SIZE_W;
    localparam int PAD_CNT  = DATA_W - CNT_W;
    localparam int PAD_DEST = DATA_W - DEST_W;

    csr_sel_t  sel;
    dma_stat_t stat;
    logic      cfg_lock;
    logic      srst_wr, start_wr, cfg_ok;

    csr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (csr_addr),
        .sel  (sel)
    );

    generate
        if (LOCK_WHEN_BUSY) begin : g_lock
            assign cfg_lock = eng_busy;
        end else begin : g_nolock
            assign cfg_lock = 1'b0;
        end
    endgenerate

    csr_field #(.W(SIZE_W)) u_size (
        .clk (clk), .rst (rst), .wr_en (csr_wr && sel.size), .lock (cfg_lock),
        .d (csr_wdata[SIZE_W-1:0]), .q (dma_pkt_size)
    );

    csr_field #(.W(CNT_W)) u_cnt (
        .clk (clk), .rst (rst), .wr_en (csr_wr && sel.cnt), .lock (cfg_lock),
        .d (csr_wdata[CNT_W-1:0]), .q (dma_pkt_count)
    );

    csr_field #(.W(DEST_W)) u_dest (
        .clk (clk), .rst (rst), .wr_en (csr_wr && sel.dest), .lock (cfg_lock),
        .d (csr_wdata[DEST_W-1:0]), .q (dma_dest_addr)
    );

    csr_field #(.W(DATA_W)) u_host (
        .clk (clk), .rst (rst), .wr_en (csr_wr && sel.host), .lock (1'b0),
        .d (csr_wdata), .q (host_ctrl)
    );

    assign srst_wr  = csr_wr && sel.srst && csr_wdata[BIT_SRST];
    assign start_wr = csr_wr && sel.ctl  && csr_wdata[BIT_GO];
    assign cfg_ok   = (dma_pkt_size != '0) && (dma_pkt_count != '0);

    dma_launch_ctrl u_launch (
        .clk       (clk),
        .rst       (rst),
        .srst_wr   (srst_wr),
        .start_wr  (start_wr),
        .cfg_ok    (cfg_ok),
        .eng_busy  (eng_busy),
        .eng_done  (eng_done),
        .stat      (stat),
        .dma_start (dma_start),
        .soft_rst  (soft_rst)
    );

    always_comb begin
        csr_rdata = '0;
        unique case (1'b1)
            sel.ctl:  csr_rdata = {{PAD_STAT{1'b0}}, stat};
            sel.size: csr_rdata = {{PAD_SIZE{1'b0}}, dma_pkt_size};
            sel.cnt:  csr_rdata = {{PAD_CNT{1'b0}},  dma_pkt_count};
            sel.dest: csr_rdata = {{PAD_DEST{1'b0}}, dma_dest_addr};
            sel.host: csr_rdata = host_ctrl;
            default:  csr_rdata = '0;
        endcase
    end

    AST_START_NONZERO: assert property (@(posedge clk) disable iff (rst)
        dma_start |-> ((dma_pkt_size != '0) && (dma_pkt_count != '0))) else $error("zero-length launch"); // R5

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !any_sel(sel) |-> (csr_rdata == '0)) else $error("unmapped read nonzero"); // R9

    AST_STATUS_BUSY: assert property (@(posedge clk) disable iff (rst)
        sel.ctl |-> (csr_rdata[1] == eng_busy)) else $error("busy bit mismatch"); // R7

endmodule

// File: tb/tb_dma_csr_top.sv
module tb_dma_csr_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  csr_addr;
    logic        csr_wr;
    logic [31:0] csr_wdata;
    logic [31:0] csr_rdata;
    logic        eng_busy, eng_done;
    logic        dma_start, soft_rst;
    logic [15:0] dma_pkt_size, dma_pkt_count;
    logic [31:0] dma_dest_addr, host_ctrl;

    always #10 clk = ~clk; // 50 MHz

    dma_csr_top dut (
        .clk (clk), .rst (rst), .csr_addr (csr_addr), .csr_wr (csr_wr),
        .csr_wdata (csr_wdata), .csr_rdata (csr_rdata), .eng_busy (eng_busy),
        .eng_done (eng_done), .dma_start (dma_start), .soft_rst (soft_rst),
        .dma_pkt_size (dma_pkt_size), .dma_pkt_count (dma_pkt_count),
        .dma_dest_addr (dma_dest_addr), .host_ctrl (host_ctrl)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Behavioural reference state
    bit          m_ready, m_done, m_err, m_start, m_srst;
    int unsigned m_size, m_cnt, m_dest, m_host;

    always @(posedge clk) begin
        if (rst) begin
            m_ready = 0; m_done = 0; m_err = 0; m_start = 0; m_srst = 0;
            m_size = 0; m_cnt = 0; m_dest = 0; m_host = 0;
        end else begin
            m_start = 0;
            m_srst  = 0;
            if (eng_done) m_done = 1;
            if (csr_wr) begin
                if (csr_addr == 8'h00 && csr_wdata[0]) begin
                    m_srst = 1; m_ready = 1; m_done = 0; m_err = 0;
                end else if (csr_addr == 8'h04 && csr_wdata[0]) begin
                    if (m_ready && m_size != 0 && m_cnt != 0) begin
                        m_start = 1; m_ready = 0; m_done = 0; m_err = 0;
                    end else begin
                        m_err = 1;
                    end
                end else if (csr_addr == 8'h08 && !eng_busy) m_size = csr_wdata & 32'hFFFF;
                else if (csr_addr == 8'h0C && !eng_busy) m_cnt = csr_wdata & 32'hFFFF;
                else if (csr_addr == 8'h10 && !eng_busy) m_dest = csr_wdata;
                else if (csr_addr == 8'h14) m_host = csr_wdata;
            end
        end
    end

    function automatic logic [31:0] model_rdata(logic [7:0] a);
        case (a)
            8'h04:   return {28'd0, m_err, m_done, eng_busy, m_ready};
            8'h08:   return m_size;
            8'h0C:   return m_cnt;
            8'h10:   return m_dest;
            8'h14:   return m_host;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic compare_all();
        string rtag;
        check("R3 soft_rst", {31'd0, soft_rst}, {31'd0, m_srst});
        check("R4 dma_start", {31'd0, dma_start}, {31'd0, m_start});
        check("R2 pkt_size", {16'd0, dma_pkt_size}, m_size);
        check("R2 pkt_count", {16'd0, dma_pkt_count}, m_cnt);
        check("R2 dest_addr", dma_dest_addr, m_dest);
        check("R2 host_ctrl", host_ctrl, m_host);
        case (csr_addr)
            8'h00:                      rtag = "R3 read reset reg";
            8'h04:                      rtag = "R7 status read";
            8'h08, 8'h0C, 8'h10, 8'h14: rtag = "R2 readback";
            default:                    rtag = "R9 unmapped read";
        endcase
        check(rtag, csr_rdata, model_rdata(csr_addr));
    endtask

    task automatic step(logic [7:0] a, logic w, logic [31:0] d, logic b, logic dn);
        csr_addr = a; csr_wr = w; csr_wdata = d; eng_busy = b; eng_done = dn;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(logic [7:0] a, logic b);
        step(a, 1'b0, 32'd0, b, 1'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; csr_addr = 0; csr_wr = 0; csr_wdata = 0; eng_busy = 0; eng_done = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R1: reset state at the ports
        check("R1 start after reset", {31'd0, dma_start}, 32'd0);
        check("R1 srst after reset", {31'd0, soft_rst}, 32'd0);
        check("R1 size after reset", {16'd0, dma_pkt_size}, 32'd0);
        check("R1 host after reset", host_ctrl, 32'd0);
        idle(8'h04, 1'b0);
        check("R1 status after reset", csr_rdata, 32'd0);

        // R6: launch while disarmed straight after hardware reset
        step(8'h08, 1, 32'hABCD_0040, 0, 0);
        step(8'h0C, 1, 32'h0000_0003, 0, 0);
        step(8'h10, 1, 32'h8000_1000, 0, 0);
        step(8'h04, 1, 32'h1, 0, 0);
        check("R6 no start when disarmed", {31'd0, dma_start}, 32'd0);
        check("R6 err set when disarmed", csr_rdata, 32'h8);

        // R3: reset write with bit0 = 0 does nothing; with 1 arms
        step(8'h00, 1, 32'hFFFF_FFFE, 0, 0);
        check("R3 bit0 clear no pulse", {31'd0, soft_rst}, 32'd0);
        step(8'h00, 1, 32'h1, 0, 0);
        check("R3 soft_rst pulse", {31'd0, soft_rst}, 32'd1);
        idle(8'h04, 0);
        check("R3 pulse one cycle", {31'd0, soft_rst}, 32'd0);
        check("R3 armed and clear", csr_rdata, 32'h1);

        // R9: ctl write with bit0 = 0 and unmapped writes have no effect
        step(8'h04, 1, 32'hFFFF_FFFE, 0, 0);
        check("R9 ctl bit0 clear", csr_rdata, 32'h1);
        step(8'h05, 1, 32'h1, 0, 0);
        step(8'h18, 1, 32'hFFFF_FFFF, 0, 0);
        step(8'hFC, 1, 32'h1, 0, 0);
        idle(8'h04, 0);
        check("R9 status untouched", csr_rdata, 32'h1);

        // R4: accepted launch, then immediate relaunch refused (R6)
        step(8'h04, 1, 32'h1, 0, 0);
        check("R4 start pulse", {31'd0, dma_start}, 32'd1);
        step(8'h04, 1, 32'h1, 1, 0);
        check("R4 single cycle", {31'd0, dma_start}, 32'd0);
        check("R6 relaunch refused err", csr_rdata, 32'hA);

        // R8: parameter writes during busy are ignored, host word still written
        step(8'h08, 1, 32'h0000_0777, 1, 0);
        step(8'h0C, 1, 32'h0000_0000, 1, 0);
        step(8'h10, 1, 32'h1234_5678, 1, 0);
        step(8'h14, 1, 32'hCAFE_F00D, 1, 0);
        check("R8 size frozen", {16'd0, dma_pkt_size}, 32'h40);
        check("R8 dest frozen", dma_dest_addr, 32'h8000_1000);

        // R7: done sticky
        step(8'h04, 0, 0, 1, 1);
        idle(8'h04, 0);
        check("R7 done set", csr_rdata, 32'hC);
        repeat (3) idle(8'h04, 0);
        check("R7 done held", csr_rdata, 32'hC);

        // R7: soft reset beats a simultaneous done pulse
        step(8'h00, 1, 32'h1, 0, 1);
        idle(8'h04, 0);
        check("R7 srst wins over done", csr_rdata, 32'h1);

        // R5: zero count refuses launch
        step(8'h0C, 1, 32'h0, 0, 0);
        step(8'h04, 1, 32'h1, 0, 0);
        check("R5 no start zero count", {31'd0, dma_start}, 32'd0);
        idle(8'h04, 0);
        check("R5 err zero count", csr_rdata, 32'h9);
        step(8'h0C, 1, 32'h5, 0, 0);
        step(8'h08, 1, 32'h0, 0, 0);
        step(8'h04, 1, 32'h1, 0, 0);
        check("R5 no start zero size", {31'd0, dma_start}, 32'd0);
        step(8'h08, 1, 32'h100, 0, 0);

        // R4/R7: accepted launch beats a simultaneous done pulse
        step(8'h04, 1, 32'h1, 0, 1);
        check("R4 start with done", {31'd0, dma_start}, 32'd1);
        idle(8'h04, 0);
        check("R7 launch clears done", csr_rdata, 32'h0);

        // Back-to-back soft resets
        step(8'h00, 1, 32'h1, 0, 0);
        step(8'h00, 1, 32'h1, 0, 0);
        check("R3 repeated soft reset", {31'd0, soft_rst}, 32'd1);

        // Mixed pseudo-random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            case ($urandom % 8)
                0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
                4: a = 8'h10; 5: a = 8'h14; 6: a = 8'h18; default: a = 8'h05;
            endcase
            d = $urandom;
            if ($urandom % 4 == 0) d = d & 32'hFFFF_0001;
            step(a, ($urandom % 3) != 0, d, ($urandom % 3) == 0, ($urandom % 7) == 0);
        end

        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1 reset again", csr_rdata | {16'd0, dma_pkt_count} | host_ctrl, 32'd0);
        finish_run();
    end

endmodule